// File: doc/BRIEF.md
# Four-Input External Interrupt Controller

The block watches four external interrupt pins and reports their events through one 32-bit control and status word on a simple register port. Each pin gets its own choice of active polarity, of edge or level detection and, in edge mode, of one-edge or two-edge triggering. A detected event sets a per-pin status flag. Software clears flags by writing ones to a pulse field, and a per-pin enable decides which flags drive the single combined interrupt line.

The pins are asynchronous. Each one passes through a two-flop synchroniser before detection. In edge mode a flag stays set until software clears it. In level mode the flag tracks the synchronised pin and cannot be cleared while the pin is still active. The word is written as a whole: every write also reloads the configuration fields, so software writes back the configuration it wants to keep along with any clear bits.

Top module: `ext_irq_ctrl`

## Requirements
- R1: After reset every configuration field and every status flag is 0, `rd_data` reads 0 and `irq_out` is 0.
- R2: Word layout, for pin x: bit x is the polarity (1 means high level or rising edge, 0 means low level or falling edge), bit 4+x is the status flag (read-only), bit 8+x is the clear pulse, bit 12+x is the interrupt enable, bit 16+x selects two-edge triggering and bit 20+x selects level mode. The configuration fields read back as written. Bits 8 to 11 and 24 to 31 always read 0.
- R3: A pin change that the first rising edge samples sets the status flag on the third rising edge, and not earlier.
- R4: In edge mode with two-edge triggering off, polarity 1 sets the flag on a rising transition only and polarity 0 on a falling transition only.
- R5: In edge mode with two-edge triggering on, either transition sets the flag, whatever the polarity.
- R6: In edge mode a flag stays set until a write puts 1 in that pin's clear bit. Clear bits of other pins, and clear bits written as 0, leave the flag unchanged.
- R7: A write of 0xF to the clear field clears all four edge-mode flags in the same cycle.
- R8: In level mode the flag equals the synchronised pin's active state: it is set while the pin is at the polarity level, a clear write does not remove it, and it drops once the pin goes inactive.
- R9: When a clear write and a new event for the same pin fall on the same clock edge, the flag ends up set.
- R10: `irq_out` is 1 exactly when some pin has both its status flag and its enable bit at 1.
- R11: A write of 0xF to the enable field enables all four pins at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_pins | input | 4 | Asynchronous external interrupt pins |
| wr_en | input | 1 | Write strobe for the control word |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Current control and status word |
| irq_out | output | 1 | Combined enabled interrupt |

## Verification
The two functions that can meet in one cycle are a software clear and the detection of a new edge on the same pin. The bench first leaves a flag set. It then gives the pin a fresh rising transition and times the clear write so that it lands on the third edge after the pin change, the edge on which the event registers. The flag is required to read 1 after that edge, and a later clear with no event must bring it to 0. The same collision is checked in level mode, where every clear write lands while the pin is active and the flag must survive it.

// File: rtl/eirq_pkg.sv
package eirq_pkg;

  typedef enum int unsigned {
    FLD_POL  = 0,
    FLD_STAT = 1,
    FLD_CLR  = 2,
    FLD_EN   = 3,
    FLD_DUAL = 4,
    FLD_LVL  = 5
  } eirq_fld_e;

  function automatic int unsigned fld_base(eirq_fld_e f, int unsigned n);
    return int'(f) * n;
  endfunction

  // Edge event seen between the previous and current synchronised sample.
  function automatic logic edge_hit(logic cur, logic prev, logic pol, logic dual);
    logic rise, fall;
    rise = cur & ~prev;
    fall = ~cur & prev;
    if (dual) return rise | fall;
    return pol ? rise : fall;
  endfunction

  // Pin at its active level.
  function automatic logic level_on(logic cur, logic pol);
    return ~(cur ^ pol);
  endfunction

endpackage

// File: rtl/eirq_channel.sv
module eirq_channel
  import eirq_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin,
  input  logic pol,
  input  logic dual,
  input  logic lvl,
  input  logic clr,
  output logic hit,
  output logic status
);

  logic [SYNC_STAGES-1:0] sync_q;
  logic                   prev_q;
  logic                   cur;
  logic                   status_q;

  generate
    if (SYNC_STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) sync_q <= '0;
        else        sync_q <= pin;
    end else begin : g_chain
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) sync_q <= '0;
        else        sync_q <= {sync_q[SYNC_STAGES-2:0], pin};
    end
  endgenerate

  assign cur = sync_q[SYNC_STAGES-1];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= cur;

  assign hit = lvl ? level_on(cur, pol) : edge_hit(cur, prev_q, pol, dual);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     status_q <= 1'b0;
    else if (hit)   status_q <= 1'b1;
    else if (lvl)   status_q <= 1'b0;
    else if (clr)   status_q <= 1'b0;
  end

  assign status = status_q;

  p_edge_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!lvl && status_q && !clr) |=> status_q);

  p_edge_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!lvl && clr && !hit) |=> !status_q);

  p_event_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
    hit |=> status_q);

  p_level_drop_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (lvl && !hit) |=> !status_q);

endmodule

// File: rtl/eirq_cfg_reg.sv
module eirq_cfg_reg
  import eirq_pkg::*;
#(
  parameter int unsigned N_IN   = 4,
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  output logic [N_IN-1:0]   pol,
  output logic [N_IN-1:0]   en,
  output logic [N_IN-1:0]   dual,
  output logic [N_IN-1:0]   lvl,
  output logic [N_IN-1:0]   clr
);

  localparam int unsigned OFF_POL  = fld_base(FLD_POL,  N_IN);
  localparam int unsigned OFF_CLR  = fld_base(FLD_CLR,  N_IN);
  localparam int unsigned OFF_EN   = fld_base(FLD_EN,   N_IN);
  localparam int unsigned OFF_DUAL = fld_base(FLD_DUAL, N_IN);
  localparam int unsigned OFF_LVL  = fld_base(FLD_LVL,  N_IN);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pol  <= '0;
      en   <= '0;
      dual <= '0;
      lvl  <= '0;
    end else if (wr_en) begin
      pol  <= wr_data[OFF_POL  +: N_IN];
      en   <= wr_data[OFF_EN   +: N_IN];
      dual <= wr_data[OFF_DUAL +: N_IN];
      lvl  <= wr_data[OFF_LVL  +: N_IN];
    end
  end

  // Clear is a single-cycle pulse taken straight from the write.
  assign clr = wr_en ? wr_data[OFF_CLR +: N_IN] : '0;

  p_enable_write_r11: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (en == $past(wr_data[OFF_EN +: N_IN])));

endmodule

// File: rtl/ext_irq_ctrl.sv
module ext_irq_ctrl
  import eirq_pkg::*;
#(
  parameter int unsigned N_IN        = 4,
  parameter int unsigned DATA_W      = 32,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_IN-1:0]   irq_pins,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_data,
  output logic              irq_out
);

  localparam int unsigned OFF_POL  = fld_base(FLD_POL,  N_IN);
  localparam int unsigned OFF_STAT = fld_base(FLD_STAT, N_IN);
  localparam int unsigned OFF_EN   = fld_base(FLD_EN,   N_IN);
  localparam int unsigned OFF_DUAL = fld_base(FLD_DUAL, N_IN);
  localparam int unsigned OFF_LVL  = fld_base(FLD_LVL,  N_IN);

  logic [N_IN-1:0] pol, en, dual, lvl, clr;
  logic [N_IN-1:0] hit, status;
  logic            unused_wr_bits;

  assign unused_wr_bits = ^wr_data;

  eirq_cfg_reg #(.N_IN(N_IN), .DATA_W(DATA_W)) u_cfg (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .pol(pol), .en(en), .dual(dual), .lvl(lvl), .clr(clr)
  );

  generate
    for (genvar i = 0; i < N_IN; i++) begin : g_ch
      eirq_channel #(.SYNC_STAGES(SYNC_STAGES)) u_ch (
        .clk(clk), .rst_n(rst_n), .pin(irq_pins[i]),
        .pol(pol[i]), .dual(dual[i]), .lvl(lvl[i]), .clr(clr[i]),
        .hit(hit[i]), .status(status[i])
      );
    end
  endgenerate

  always_comb begin
    rd_data = '0;
    rd_data[OFF_POL  +: N_IN] = pol;
    rd_data[OFF_STAT +: N_IN] = status;
    rd_data[OFF_EN   +: N_IN] = en;
    rd_data[OFF_DUAL +: N_IN] = dual;
    rd_data[OFF_LVL  +: N_IN] = lvl;
  end

  assign irq_out = |(status & en);

  p_quiet_line_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_out |-> ((rd_data[OFF_STAT +: N_IN] & rd_data[OFF_EN +: N_IN]) == '0));

  p_line_follows_r10: assert property (@(posedge clk) disable iff (!rst_n)
    irq_out |-> ((rd_data[OFF_STAT +: N_IN] & rd_data[OFF_EN +: N_IN]) != '0));

endmodule

// File: tb/ext_irq_ctrl_test.sv
module ext_irq_ctrl_test;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  irq_pins = 4'h0;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = 32'h0;
  logic [31:0] rd_data;
  logic        irq_out;

  int errors = 0;
  int checks = 0;
  logic [31:0] cfg;

  always #(CLK_PERIOD/2) clk = ~clk;

  ext_irq_ctrl uut (
    .clk(clk), .rst_n(rst_n), .irq_pins(irq_pins), .wr_en(wr_en),
    .wr_data(wr_data), .rd_data(rd_data), .irq_out(irq_out)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [31:0] d);
    wr_en = 1'b1;
    wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
    wr_data = 32'h0;
  endtask

  function automatic logic [31:0] mk_cfg(logic [3:0] p, logic [3:0] e,
                                         logic [3:0] d, logic [3:0] l);
    return {8'h00, l, d, e, 4'h0, 4'h0, p};
  endfunction

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    step(3);
    rst_n = 1'b1;
    step(2);
    // R1 reset state
    check("R1 rd_data after reset", rd_data, 32'h0);
    check("R1 irq_out after reset", {31'h0, irq_out}, 32'h0);

    // R2 layout / readback, junk in status and upper bits
    wr(32'hFFA55AFA);
    step(1);
    check("R2 readback layout", rd_data, 32'h00A5500A);

    // R3 latency: edge mode, rising, all enabled (R11 mask all)
    cfg = mk_cfg(4'hF, 4'hF, 4'h0, 4'h0);
    wr(cfg | 32'hF00);
    check("R11 enable all", {28'h0, rd_data[15:12]}, 32'hF);
    irq_pins[0] = 1'b1;
    step(2);
    check("R3 not yet after two edges", {28'h0, rd_data[7:4]}, 32'h0);
    step(1);
    check("R3 set on third edge", {28'h0, rd_data[7:4]}, 32'h1);

    // R9 clear and new event on the same edge
    irq_pins[0] = 1'b0;
    step(4);
    irq_pins[0] = 1'b1;
    step(2);
    wr(cfg | 32'h100);
    check("R9 event wins over clear", {28'h0, rd_data[7:4]}, 32'h1);
    wr(cfg | 32'h100);
    check("R9 later clear works", {28'h0, rd_data[7:4]}, 32'h0);

    // R6 selective clear
    irq_pins[1] = 1'b1;
    irq_pins[2] = 1'b1;
    step(4);
    check("R6 two flags set", {28'h0, rd_data[7:4]}, 32'h6);
    wr(cfg | 32'h200);
    check("R6 clear one only", {28'h0, rd_data[7:4]}, 32'h4);
    wr(cfg);
    check("R6 zero clear no effect", {28'h0, rd_data[7:4]}, 32'h4);

    // R10 enable gating, flag 2 set
    wr(mk_cfg(4'hF, 4'h0, 4'h0, 4'h0));
    check("R10 disabled line low", {31'h0, irq_out}, 32'h0);
    wr(mk_cfg(4'hF, 4'h4, 4'h0, 4'h0));
    check("R10 enabled line high", {31'h0, irq_out}, 32'h1);
    wr(mk_cfg(4'hF, 4'h2, 4'h0, 4'h0));
    check("R10 other enable low", {31'h0, irq_out}, 32'h0);
    irq_pins = 4'h0;
    step(4);
    wr(mk_cfg(4'hF, 4'hF, 4'h0, 4'h0) | 32'hF00);
    check("R7 clear all", {28'h0, rd_data[7:4]}, 32'h0);

    // Sweep: every pin, every polarity / two-edge / level combination
    for (int i = 0; i < 4; i++) begin
      for (int m = 0; m < 8; m++) begin
        logic s, b, l;
        logic [3:0] exp_st;
        s = m[0]; b = m[1]; l = m[2];
        cfg = mk_cfg({4{s}}, 4'hF, {4{b}}, {4{l}});
        wr(cfg);
        step(1);
        wr(cfg | 32'hF00);
        step(1);
        exp_st = l ? {4{~s}} : 4'h0;
        check($sformatf("R8 baseline pin%0d mode%0d", i, m), {28'h0, rd_data[7:4]}, {28'h0, exp_st});
        irq_pins[i] = 1'b1;
        step(4);
        exp_st = l ? {4{~s}} : 4'h0;
        exp_st[i] = l ? s : (b | s);
        check($sformatf("R4 R5 R8 rise pin%0d mode%0d", i, m), {28'h0, rd_data[7:4]}, {28'h0, exp_st});
        check($sformatf("R10 line pin%0d mode%0d", i, m), {31'h0, irq_out}, {31'h0, |exp_st});
        wr(cfg | 32'hF00);
        step(1);
        exp_st = l ? {4{~s}} : 4'h0;
        exp_st[i] = l ? s : 1'b0;
        check($sformatf("R7 R8 clear-all pin%0d mode%0d", i, m), {28'h0, rd_data[7:4]}, {28'h0, exp_st});
        irq_pins[i] = 1'b0;
        step(4);
        exp_st = l ? {4{~s}} : 4'h0;
        exp_st[i] = l ? ~s : (b | ~s);
        check($sformatf("R4 R5 R8 fall pin%0d mode%0d", i, m), {28'h0, rd_data[7:4]}, {28'h0, exp_st});
        wr(cfg | 32'hF00);
        step(1);
      end
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule